// File: doc/BRIEF.md
# Dual-Channel Reload Down-Counter Timer

This block is a memory-mapped timer with two identical down-counting channels behind a simple word-addressed register bus. Channel 0 is used as an event timer that raises a level interrupt. Channel 1 is used as a free-running time base: it counts down from all-ones, so software reads elapsed time as the bitwise inverse of the count. Each channel has a control/status register, a read-only current count and two reload registers.

Counting is paced by a shared prescaler that issues one tick every two clocks. Software arms a channel by writing the trigger bit together with count enable. On the next tick the count is loaded from reload register 1. At each later tick the count drops by one. A tick that finds the count at zero is an underflow. An underflow sets a sticky flag, toggles a status level bit and then either reloads the count (periodic mode) or stops the channel (one-shot mode). Reload register 2 is plain read/write storage. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `dual_reload_timer`

## Requirements
- R1: While reset is held, and for two clocks after it is released, every register reads 0 and `irq` is 0. Reset release passes through a two-stage synchronizer.
- R2: Channel n sits at byte address 0x10*n. Offset 0x0 is the control/status word, 0x4 is the current count, 0x8 is reload 1 and 0xC is reload 2. Address bits [1:0] are ignored. `bus_rdata` shows the addressed register in the same cycle. Writes to the count offset are ignored.
- R3: The count changes only on a prescaler tick. A tick falls on every second rising edge. The first tick falls on the second edge after the internal reset is released.
- R4: Control/status bits: 5 output level (read-only), 4 reload enable, 3 interrupt enable, 2 underflow flag, 1 count enable, 0 trigger (reads 1 while a load is pending). Bits 31:6 read 0.
- R5: A control write with bits 1 and 0 both set arms a load. At the next tick the count takes reload 1, the channel starts running and the trigger bit reads 0 again.
- R6: While running with count enable set, each tick that finds a non-zero count decrements it by one.
- R7: A tick that finds a running count at 0 sets the underflow flag and toggles the output level bit. With reload enable set, the count takes reload 1 and keeps running. With reload enable clear, the count stays 0 and the channel stops (one-shot).
- R8: Writing 0 to bit 2 clears the underflow flag. Writing 1 to bit 2 leaves it unchanged. If an underflow falls in the same cycle as a clearing write, the flag stays set.
- R9: `irq[n]` is high exactly while channel n has both its underflow flag and its interrupt enable set.
- R10: A control write with bit 1 clear stops the channel at once and cancels a pending load. The count keeps its value, even in a tick cycle.
- R11: With reload 1 at all-ones and reload, count enable and trigger written, the channel counts down continuously from 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address: bit 4 picks the channel, bits 3:2 the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 2 | Level interrupt per channel |

## Verification
Two events can land in the same clock: an underflow setting the flag on a tick, and a software write that clears the flag. The bench provokes this by setting reload 1 to zero in periodic mode, so every tick underflows. It then issues the clearing write in exactly the cycle before a tick edge, and again in a non-tick cycle. It judges that the flag survives the first write and drops after the second. A second overlap, a stop write landing on a tick, is covered by random traffic against a cycle-level model in the bench.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // control/status bit positions
  localparam int CSR_TRG = 0;
  localparam int CSR_EN  = 1;
  localparam int CSR_UF  = 2;
  localparam int CSR_IE  = 3;
  localparam int CSR_RLD = 4;
  localparam int CSR_OUT = 5;
  localparam int CSR_BITS = 6;

  typedef enum logic [1:0] {
    REG_CSR = 2'd0,
    REG_CNT = 2'd1,
    REG_RL1 = 2'd2,
    REG_RL2 = 2'd3
  } tmr_reg_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 2,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [PW-1:0] pc_q, pc_n;

  assign tick_o = (pc_q == PW'(DIV - 1));

  always_comb begin
    pc_n = tick_o ? '0 : pc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_n;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          csr_we_i,
  input  logic          rl1_we_i,
  input  logic          rl2_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] csr_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rl1_o,
  output logic [DW-1:0] rl2_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] rl1_q, rl2_q;
  logic en_q, en_n, ie_q, ie_n, rld_q, rld_n;
  logic uf_q, uf_n, out_q, out_n;
  logic run_q, run_n, pend_q, pend_n;
  logic halt, step, uf_set, uf_clr;

  assign halt   = csr_we_i && !wdata_i[CSR_EN];
  assign step   = tick_i && en_q && !halt;
  assign uf_clr = csr_we_i && !wdata_i[CSR_UF];

  always_comb begin
    cnt_n  = cnt_q;
    run_n  = run_q;
    pend_n = pend_q;
    out_n  = out_q;
    uf_set = 1'b0;
    en_n   = en_q;
    ie_n   = ie_q;
    rld_n  = rld_q;
    if (step) begin
      if (pend_q) begin
        cnt_n  = rl1_q;
        run_n  = 1'b1;
        pend_n = 1'b0;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          uf_set = 1'b1;
          out_n  = ~out_q;
          if (rld_q) cnt_n = rl1_q;
          else       run_n = 1'b0;
        end else begin
          cnt_n = cnt_q - DW'(1);
        end
      end
    end
    if (csr_we_i) begin
      en_n  = wdata_i[CSR_EN];
      ie_n  = wdata_i[CSR_IE];
      rld_n = wdata_i[CSR_RLD];
      if (!wdata_i[CSR_EN]) begin
        run_n  = 1'b0;
        pend_n = 1'b0;
      end else if (wdata_i[CSR_TRG]) begin
        pend_n = 1'b1;
      end
    end
    uf_n = uf_set | (uf_q & ~uf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= 1'b0;
      uf_q   <= 1'b0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      rld_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      pend_q <= pend_n;
      out_q  <= out_n;
      uf_q   <= uf_n;
      en_q   <= en_n;
      ie_q   <= ie_n;
      rld_q  <= rld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rl1_q <= '0;
    else if (rl1_we_i) rl1_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rl2_q <= '0;
    else if (rl2_we_i) rl2_q <= wdata_i;
  end

  always_comb begin
    csr_o          = '0;
    csr_o[CSR_TRG] = pend_q;
    csr_o[CSR_EN]  = en_q;
    csr_o[CSR_UF]  = uf_q;
    csr_o[CSR_IE]  = ie_q;
    csr_o[CSR_RLD] = rld_q;
    csr_o[CSR_OUT] = out_q;
  end

  assign cnt_o = cnt_q;
  assign rl1_o = rl1_q;
  assign rl2_o = rl2_q;
  assign irq_o = uf_q & ie_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  // R8
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !uf_clr) |=> uf_q);
  // R5
  trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_q && pend_q && !csr_we_i) |=> (run_q && !pend_q && cnt_q == $past(rl1_q)));
  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_q && run_q && !pend_q && !rld_q && cnt_q == '0 && !csr_we_i)
      |=> (!run_q && uf_q && cnt_q == '0));
  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!run_q && !pend_q && $stable(cnt_q)));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import timer_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DW      = 32,
  parameter int PRE_DIV = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic           sys_rst_n;
  logic           tick;
  logic [CH_W-1:0] ch_sel;
  tmr_reg_e       reg_sel;
  logic [DW-1:0]  csr_w [NUM_CH];
  logic [DW-1:0]  cnt_w [NUM_CH];
  logic [DW-1:0]  rl1_w [NUM_CH];
  logic [DW-1:0]  rl2_w [NUM_CH];

  assign ch_sel  = bus_addr[ADDR_W-1:4];
  assign reg_sel = tmr_reg_e'(bus_addr[3:2]);

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (sys_rst_n)
  );

  tmr_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_we && (ch_sel == CH_W'(c));
    tmr_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .tick_i   (tick),
      .csr_we_i (hit && reg_sel == REG_CSR),
      .rl1_we_i (hit && reg_sel == REG_RL1),
      .rl2_we_i (hit && reg_sel == REG_RL2),
      .wdata_i  (bus_wdata),
      .csr_o    (csr_w[c]),
      .cnt_o    (cnt_w[c]),
      .rl1_o    (rl1_w[c]),
      .rl2_o    (rl2_w[c]),
      .irq_o    (irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) begin
        case (reg_sel)
          REG_CSR: bus_rdata = csr_w[c];
          REG_CNT: bus_rdata = cnt_w[c];
          REG_RL1: bus_rdata = rl1_w[c];
          default: bus_rdata = rl2_w[c];
        endcase
      end
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !sys_rst_n |-> (irq == '0));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(irq[0]) |-> (csr_w[0][CSR_UF] && csr_w[0][CSR_IE]));
endmodule

// File: tb/dual_reload_timer_bench.sv
`timescale 1ns/100ps
module dual_reload_timer_bench;
  localparam int PRE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0]  mrs;
  int          mpc;
  logic        mtick;
  logic [31:0] m_cnt [2];
  logic [31:0] m_rl1 [2];
  logic [31:0] m_rl2 [2];
  logic        m_en [2], m_ie [2], m_rld [2], m_uf [2], m_out [2], m_run [2], m_pend [2];

  always #2.5 clk = ~clk;

  dual_reload_timer u_dual_reload_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs = 2'b00;
      mpc = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = '0; m_rl1[c] = '0; m_rl2[c] = '0;
        m_en[c] = 0; m_ie[c] = 0; m_rld[c] = 0; m_uf[c] = 0;
        m_out[c] = 0; m_run[c] = 0; m_pend[c] = 0;
      end
    end else begin
      if (mrs[1]) begin
        mtick = (mpc == PRE - 1);
        mpc = mtick ? 0 : mpc + 1;
        for (int c = 0; c < 2; c++) begin
          logic wc, w1, w2, halt, ufs;
          wc = bus_we && bus_addr[4] == c[0] && bus_addr[3:2] == 2'd0;
          w1 = bus_we && bus_addr[4] == c[0] && bus_addr[3:2] == 2'd2;
          w2 = bus_we && bus_addr[4] == c[0] && bus_addr[3:2] == 2'd3;
          halt = wc && !bus_wdata[1];
          ufs = 1'b0;
          if (mtick && m_en[c] && !halt) begin
            if (m_pend[c]) begin
              m_cnt[c] = m_rl1[c]; m_run[c] = 1; m_pend[c] = 0;
            end else if (m_run[c]) begin
              if (m_cnt[c] == 0) begin
                ufs = 1'b1; m_out[c] = ~m_out[c];
                if (m_rld[c]) m_cnt[c] = m_rl1[c];
                else m_run[c] = 0;
              end else m_cnt[c] = m_cnt[c] - 1;
            end
          end
          m_uf[c] = ufs | (m_uf[c] & !(wc && !bus_wdata[2]));
          if (wc) begin
            m_en[c] = bus_wdata[1]; m_ie[c] = bus_wdata[3]; m_rld[c] = bus_wdata[4];
            if (!bus_wdata[1]) begin m_run[c] = 0; m_pend[c] = 0; end
            else if (bus_wdata[0]) m_pend[c] = 1;
          end
          if (w1) m_rl1[c] = bus_wdata;
          if (w2) m_rl2[c] = bus_wdata;
        end
      end
      mrs = {mrs[0], 1'b1};
    end
  end

  function automatic logic [31:0] model_read(input logic [4:0] a);
    int c;
    c = int'(a[4]);
    case (a[3:2])
      2'd0: return {26'd0, m_out[c], m_rld[c], m_ie[c], m_uf[c], m_en[c], m_pend[c]};
      2'd1: return m_cnt[c];
      2'd2: return m_rl1[c];
      default: return m_rl2[c];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [4:0] a);
    case (a[3:2])
      2'd0: return "R4 csr";
      2'd1: return "R6 count";
      default: return "R2 reload";
    endcase
  endfunction

  task automatic wr_now(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
    chk(tag_of(a), bus_rdata, model_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9: interrupt level checked every cycle
  always @(negedge clk) begin
    if (mrs == 2'b11 && !done) begin
      #2;
      chk("R9 irq", {30'd0, irq}, {30'd0, m_uf[1] & m_ie[1], m_uf[0] & m_ie[0]});
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int seed_init;
    seed_init = $urandom(32'd20240601);

    // R1: reset state, during and after reset
    idle(3);
    @(negedge clk); #1;
    chk("R1 irq in reset", {30'd0, irq}, 32'd0);
    rst_n = 1'b1;
    idle(3);
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v);
      chk("R1 reset value", v, 32'd0);
    end

    // R2: count offset is read-only
    wr(5'h04, 32'h55);
    rd(5'h04, v);
    chk("R2 count write ignored", v, 32'd0);
    wr(5'h1C, 32'hA5A5_0F0F);
    rd(5'h1C, v);
    chk("R2 reload2 storage", v, 32'hA5A5_0F0F);

    // R5 R6 R7: one-shot on channel 0
    wr(5'h08, 32'd3);
    wr(5'h00, 32'h0B);
    rd(5'h00, v);
    chk("R5 trigger pending", v & 32'h1, 32'h1);
    idle(20);
    rd(5'h04, v);
    chk("R7 one-shot count", v, 32'd0);
    rd(5'h00, v);
    chk("R7 one-shot csr", v, 32'h2E);
    chk("R9 irq after underflow", {31'd0, irq[0]}, 32'd1);

    // R8: writing 1 keeps the flag, writing 0 clears it
    wr(5'h00, 32'h0E);
    rd(5'h00, v);
    chk("R8 write one keeps flag", v & 32'h4, 32'h4);
    wr(5'h00, 32'h0A);
    rd(5'h00, v);
    chk("R8 write zero clears flag", v & 32'h4, 32'h0);
    chk("R9 irq dropped", {31'd0, irq[0]}, 32'd0);

    // R11: free-running full range on channel 1
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h10, 32'h13);
    idle(12);
    rd(5'h14, v);
    chk("R11 free-run near top", {31'd0, (v >= 32'hFFFF_FFF0 && v != 32'hFFFF_FFFF)}, 32'd1);
    // R10: stop keeps count
    wr(5'h10, 32'h0);
    rd(5'h14, v);
    idle(6);
    rd(5'h14, v2);
    chk("R10 stopped count frozen", v2, v);

    // R8 collision: underflow every tick, clear lands on a tick edge
    wr(5'h08, 32'd0);
    wr(5'h00, 32'h1B);
    idle(6);
    @(negedge clk);
    while (mpc != PRE - 1) @(negedge clk);
    wr_now(5'h00, 32'h1A);
    rd(5'h00, v);
    chk("R8 set wins over clear", v & 32'h4, 32'h4);
    @(negedge clk);
    while (mpc == PRE - 1) @(negedge clk);
    wr_now(5'h00, 32'h1A);
    @(negedge clk); bus_addr = 5'h00; #1;
    chk("R8 clear off-tick", bus_rdata & 32'h4, 32'h0);
    wr(5'h00, 32'h0);

    // random traffic against the model
    for (int i = 0; i < 2500; i++) begin
      logic [4:0] a;
      logic [31:0] d;
      a = 5'($urandom_range(0, 7) * 4);
      if (a[3:2] == 2'd0) begin
        d = {26'd0, 6'($urandom_range(0, 63))};
        if ($urandom_range(0, 3) != 0) d[1] = 1'b1;
      end else d = 32'($urandom_range(0, 12));
      if ($urandom_range(0, 2) == 0) wr(a, d);
      else rd(a, v);
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 6)));
    end

    finish_run();
  end
endmodule